// File: doc/BRIEF.md
# BCD Calendar Clock with Halt

This block keeps a time of day and a calendar as eight byte-wide registers, all time fields in packed BCD. A one-cycle pulse on the tick input marks one elapsed second. On each such pulse the seconds advance, and a rollover carries through minutes, hours, day of week, date, month and a two-digit year. The date rollover follows the length of the current month, and February gains a 29th day in years divisible by four.

Software-side logic loads any register through a byte write port addressed 0 to 7. All eight registers are presented at once on a flat output bus, so a consumer can capture a coherent snapshot in a single cycle. A halt flag in the top bit of the seconds register freezes the count. The hours register holds either a 24-hour value or a 12-hour value with a PM flag. A control byte is stored with only four of its bits kept; nothing inside the block acts on them.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the registers read seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01, year 0x00 and control 0x00.
- R2: A write with address a stores the data in register a. Register a appears on regsOut bits 8a+7 down to 8a after the next clock edge. The addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. Bits with no meaning always read zero: bit 7 of minutes and hours, bits 7:3 of day of week, bits 7:6 of date and bits 7:5 of month.
- R3: A write to the control register keeps only bits 7, 4, 1 and 0 (mask 0x93). Every other control bit reads zero.
- R4: Seconds (bits 6:0) and minutes count in BCD and wrap from 0x59 to 0x00. A seconds wrap advances minutes in the same edge, and a minutes wrap advances hours.
- R5: With hours bit 6 clear (24-hour), bits 5:0 hold BCD hours. They wrap from 0x23 to 0x00 and then advance the day.
- R6: With hours bit 6 set (12-hour), bit 5 is PM and bits 4:0 hold BCD hours counting 12, 1, ..., 11. Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM advances the day.
- R7: On each day advance, the day of week (bits 2:0) counts 1 to 7 and wraps from 7 to 1.
- R8: On each day advance, the date wraps to 0x01 after the last day of the month and carries into the month. Months 4, 6, 9 and 11 have 30 days, and the other months except February have 31. The month wraps 0x12 to 0x01 and carries into the year, and the year wraps 0x99 to 0x00.
- R9: February has 29 days when the BCD year is divisible by four, and 28 days otherwise.
- R10: While seconds bit 7 is set, ticks change no register. Writing bit 7 as zero resumes counting from the held values.
- R11: A write to the seconds register in a tick cycle stores the written value and drops that tick. A write to any other register in a tick cycle stores the written value in that register while the other fields advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle pulse per elapsed second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address for the write |
| wrData | input | 8 | Write data |
| regsOut | output | 64 | All eight registers, register a at bits 8a+7:8a |

## Verification
The hardest cases to reach from the ports are the full carry cascades: the one tick that turns 11:59:59 PM on the last day of December 99 into a new day, month and year, and the February edge in leap and common years. Tick-driven counting alone would need millions of cycles to get there. Directed steps therefore load the fields one at a time through the write port and then give a single tick. A constrained random phase writes only legal field values, random hour formats and an occasional halt bit. It also lets ticks and writes collide in the same cycle, which exercises the ordering rule between a write and an advance.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int REG_COUNT = 8;
  localparam int REG_W     = 8;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DOW  = 3;
  localparam int IDX_DATE = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CTRL = 7;

  typedef struct packed {
    logic                 advance;
    logic [REG_COUNT-1:0] wrSel;
  } calStrobes_t;

  // bits a write may leave set in each register
  function automatic logic [REG_W-1:0] keepMask(input int idx, input logic [REG_W-1:0] ctrlKeep);
    case (idx)
      IDX_SEC:  keepMask = 8'hFF;
      IDX_MIN:  keepMask = 8'h7F;
      IDX_HOUR: keepMask = 8'h7F;
      IDX_DOW:  keepMask = 8'h07;
      IDX_DATE: keepMask = 8'h3F;
      IDX_MON:  keepMask = 8'h1F;
      IDX_YEAR: keepMask = 8'hFF;
      default:  keepMask = ctrlKeep;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] resetValue(input int idx);
    case (idx)
      IDX_DOW, IDX_DATE, IDX_MON: resetValue = 8'h01;
      default:                    resetValue = 8'h00;
    endcase
  endfunction

  // two-digit BCD increment, units 9 carry into tens
  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcdInc = {v[7:4] + 4'd1, 4'h0};
    else                bcdInc = {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len (
  input  logic [4:0] monthBcd,
  input  logic [7:0] yearBcd,
  output logic [5:0] lastDay
);
  logic leapYear;

  // divisible by four: even tens with units 0/4/8, odd tens with units 2/6
  always_comb begin
    if (yearBcd[4] == 1'b0)
      leapYear = (yearBcd[3:0] == 4'd0) || (yearBcd[3:0] == 4'd4) || (yearBcd[3:0] == 4'd8);
    else
      leapYear = (yearBcd[3:0] == 4'd2) || (yearBcd[3:0] == 4'd6);
  end

  always_comb begin
    case (monthBcd)
      5'h02:                      lastDay = leapYear ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: lastDay = 6'h30;
      default:                    lastDay = 6'h31;
    endcase
  end

  // R9: February never reports more than 29 days
  always_comb begin
    if (monthBcd == 5'h02) a_r9_feb_len : assert (lastDay != 6'h30 && lastDay != 6'h31);
  end

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int REGS   = REG_COUNT,
  localparam int ADDR_W = $clog2(REGS)
) (
  input  logic              tickIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              haltNow,
  output calStrobes_t       strobes
);
  logic [REGS-1:0] sel;

  for (genvar i = 0; i < REGS; i++) begin : gDecode
    assign sel[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  always_comb begin
    strobes.wrSel   = sel;
    // a seconds write owns the cycle; a halted clock ignores the tick
    strobes.advance = tickIn && !haltNow && !sel[IDX_SEC];
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter logic [REG_W-1:0] CTRL_KEEP = 8'h93
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  calStrobes_t                  strobes,
  input  logic [REG_W-1:0]             wrData,
  output logic                         haltNow,
  output logic [REG_COUNT*REG_W-1:0]   regsOut
);
  logic [REG_COUNT-1:0][REG_W-1:0] regs;
  logic [REG_W-1:0]                advVal [REG_COUNT];
  logic [REG_COUNT-1:0]            incVec;

  logic       secWrap, minWrap, hourCarry, dateWrap, monWrap;
  logic [7:0] hourNext;
  logic [7:0] hourVal;
  logic [5:0] lastDay;

  cal_month_len uMonthLen (
    .monthBcd (regs[IDX_MON][4:0]),
    .yearBcd  (regs[IDX_YEAR]),
    .lastDay  (lastDay)
  );

  // hours: 12-hour field is bits 4:0, 24-hour field is bits 5:0
  always_comb begin
    hourCarry = 1'b0;
    if (regs[IDX_HOUR][6]) begin
      hourVal = {3'b000, regs[IDX_HOUR][4:0]};
      if (hourVal == 8'h11) begin
        hourNext  = {2'b01, ~regs[IDX_HOUR][5], 5'h12};
        hourCarry = regs[IDX_HOUR][5];
      end else if (hourVal == 8'h12) begin
        hourNext = {2'b01, regs[IDX_HOUR][5], 5'h01};
      end else begin
        hourNext = {2'b01, regs[IDX_HOUR][5], bcdInc(hourVal)[4:0]};
      end
    end else begin
      hourVal = {2'b00, regs[IDX_HOUR][5:0]};
      if (hourVal == 8'h23) begin
        hourNext  = 8'h00;
        hourCarry = 1'b1;
      end else begin
        hourNext = {2'b00, bcdInc(hourVal)[5:0]};
      end
    end
  end

  always_comb begin
    secWrap  = (regs[IDX_SEC][6:0] == 7'h59);
    minWrap  = (regs[IDX_MIN][6:0] == 7'h59);
    dateWrap = (regs[IDX_DATE][5:0] == lastDay);
    monWrap  = (regs[IDX_MON][4:0] == 5'h12);

    incVec[IDX_SEC]  = strobes.advance;
    incVec[IDX_MIN]  = incVec[IDX_SEC] && secWrap;
    incVec[IDX_HOUR] = incVec[IDX_MIN] && minWrap;
    incVec[IDX_DOW]  = incVec[IDX_HOUR] && hourCarry;
    incVec[IDX_DATE] = incVec[IDX_DOW];
    incVec[IDX_MON]  = incVec[IDX_DATE] && dateWrap;
    incVec[IDX_YEAR] = incVec[IDX_MON] && monWrap;
    incVec[IDX_CTRL] = 1'b0;

    advVal[IDX_SEC]  = secWrap ? 8'h00 : {1'b0, bcdInc({1'b0, regs[IDX_SEC][6:0]})[6:0]};
    advVal[IDX_MIN]  = minWrap ? 8'h00 : {1'b0, bcdInc({1'b0, regs[IDX_MIN][6:0]})[6:0]};
    advVal[IDX_HOUR] = hourNext;
    advVal[IDX_DOW]  = (regs[IDX_DOW][2:0] == 3'd7) ? 8'h01 : {5'b0, regs[IDX_DOW][2:0] + 3'd1};
    advVal[IDX_DATE] = dateWrap ? 8'h01 : {2'b00, bcdInc({2'b00, regs[IDX_DATE][5:0]})[5:0]};
    advVal[IDX_MON]  = monWrap ? 8'h01 : {3'b000, bcdInc({3'b000, regs[IDX_MON][4:0]})[4:0]};
    advVal[IDX_YEAR] = (regs[IDX_YEAR] == 8'h99) ? 8'h00 : bcdInc(regs[IDX_YEAR]);
    advVal[IDX_CTRL] = regs[IDX_CTRL];
  end

  // a write replaces whatever the advance would have put in that register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= resetValue(i);
    end else begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (strobes.wrSel[i])  regs[i] <= wrData & keepMask(i, CTRL_KEEP);
        else if (incVec[i])    regs[i] <= advVal[i];
      end
    end
  end

  assign haltNow = regs[IDX_SEC][7];

  for (genvar i = 0; i < REG_COUNT; i++) begin : gOut
    assign regsOut[i*REG_W +: REG_W] = regs[i];
  end

  // R10: halted and untouched, nothing moves
  a_r10_halt_freeze : assert property (@(posedge clk) disable iff (!rstN)
    (regs[IDX_SEC][7] && strobes.wrSel == '0) |=> $stable(regs));

  // R4: seconds wrap on an advance from 59
  a_r4_sec_wrap : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && regs[IDX_SEC][6:0] == 7'h59) |=> (regs[IDX_SEC] == 8'h00));

  // R7: day of week stays in 1..7 unless rewritten
  a_r7_dow_range : assert property (@(posedge clk) disable iff (!rstN)
    (regs[IDX_DOW][2:0] != 3'd0 && !strobes.wrSel[IDX_DOW]) |=> (regs[IDX_DOW][2:0] != 3'd0));

  // R10: an advance never sets the halt flag
  a_r10_advance_keeps_run : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.wrSel[IDX_SEC]) |=> !regs[IDX_SEC][7]);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_pkg::*;
#(
  parameter int               DATA_W    = REG_W,
  parameter int               NUM_REGS  = REG_COUNT,
  parameter logic [REG_W-1:0] CTRL_KEEP = 8'h93,
  localparam int              ADDR_W    = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tickIn,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NUM_REGS*DATA_W-1:0] regsOut
);
  calStrobes_t strobes;
  logic        haltNow;

  cal_ctrl #(.REGS(NUM_REGS)) uCtrl (
    .tickIn  (tickIn),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .haltNow (haltNow),
    .strobes (strobes)
  );

  cal_datapath #(.CTRL_KEEP(CTRL_KEEP)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .haltNow (haltNow),
    .regsOut (regsOut)
  );

  // R11: a seconds write wins over a tick in the same cycle
  a_r11_sec_write_wins : assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(IDX_SEC)) |=> (regsOut[DATA_W-1:0] == $past(wrData)));

  // R3: control bits outside the keep mask stay zero
  a_r3_ctrl_mask : assert property (@(posedge clk) disable iff (!rstN)
    ((regsOut[IDX_CTRL*DATA_W +: DATA_W] & ~CTRL_KEEP) == '0));

endmodule

// File: tb/tb_bcd_calendar_clock.sv
module tb_bcd_calendar_clock;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [63:0] regsOut;
  logic [63:0] expRegs;
  int          testCount = 0;
  int          failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar_clock dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .regsOut(regsOut)
  );

  function automatic int bcd2bin(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin2bcd(input int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] maskOf(input int a);
    case (a)
      1, 2: return 8'h7F;
      3: return 8'h07;
      4: return 8'h3F;
      5: return 8'h1F;
      7: return 8'h93;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int monthDays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // one second of calendar arithmetic, done in binary
  function automatic logic [63:0] advanceModel(input logic [63:0] r);
    logic [63:0] n = r;
    int s, mi, h, dw, dt, mo, yr;
    bit pm, twelve, carry;
    s = bcd2bin({1'b0, r[6:0]});
    if (s < 59) begin n[7:0] = bin2bcd(s + 1); return n; end
    n[7:0] = 8'h00;
    mi = bcd2bin({1'b0, r[14:8]});
    if (mi < 59) begin n[15:8] = bin2bcd(mi + 1); return n; end
    n[15:8] = 8'h00;
    twelve = r[22];
    carry = 1'b0;
    if (twelve) begin
      pm = r[21];
      h = bcd2bin({3'b0, r[20:16]});
      if (h == 11) begin h = 12; carry = pm; pm = !pm; end
      else if (h == 12) h = 1;
      else h = h + 1;
      n[23:16] = {2'b01, pm, bin2bcd(h)[4:0]};
    end else begin
      h = bcd2bin({2'b0, r[21:16]});
      if (h == 23) begin h = 0; carry = 1'b1; end else h = h + 1;
      n[23:16] = bin2bcd(h);
    end
    if (!carry) return n;
    dw = int'(r[26:24]);
    n[31:24] = (dw == 7) ? 8'h01 : 8'(dw + 1);
    dt = bcd2bin(r[39:32]);
    mo = bcd2bin(r[47:40]);
    yr = bcd2bin(r[55:48]);
    if (dt < monthDays(mo, yr)) begin n[39:32] = bin2bcd(dt + 1); return n; end
    n[39:32] = 8'h01;
    if (mo < 12) begin n[47:40] = bin2bcd(mo + 1); return n; end
    n[47:40] = 8'h01;
    n[55:48] = (yr == 99) ? 8'h00 : bin2bcd(yr + 1);
    return n;
  endfunction

  function automatic logic [63:0] modelStep(input logic [63:0] r, input bit t,
                                            input bit w, input int a, input logic [7:0] d);
    logic [63:0] n = r;
    if (t && !r[7] && !(w && a == 0)) n = advanceModel(r);
    if (w) n[a*8 +: 8] = d & maskOf(a);
    return n;
  endfunction

  task automatic checkRegs(input string tag);
    testCount++;
    if (regsOut !== expRegs) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, regsOut, expRegs);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic doCycle(input bit t, input bit w, input int a, input logic [7:0] d, input string tag);
    tickIn = t; wrEn = w; wrAddr = 3'(a); wrData = d;
    expRegs = modelStep(expRegs, t, w, a, d);
    @(negedge clk);
    tickIn = 1'b0; wrEn = 1'b0;
    checkRegs(tag);
  endtask

  task automatic loadTime(input logic [7:0] hr, input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr, input string tag);
    doCycle(0, 1, 0, 8'h59, tag);
    doCycle(0, 1, 1, 8'h59, tag);
    doCycle(0, 1, 2, hr, tag);
    doCycle(0, 1, 3, dw, tag);
    doCycle(0, 1, 4, dt, tag);
    doCycle(0, 1, 5, mo, tag);
    doCycle(0, 1, 6, yr, tag);
  endtask

  function automatic logic [7:0] randValid(input int a);
    int h;
    case (a)
      0: return {($urandom_range(7) == 0), 1'b0, bin2bcd(int'($urandom_range(59)))[5:0]} | {1'b0, bin2bcd(int'($urandom_range(59)))[6:0] & 7'h00};
      1: return bin2bcd(int'($urandom_range(59)));
      2: begin
        if ($urandom_range(1) == 1) begin
          h = int'($urandom_range(12, 1));
          return {2'b01, 1'($urandom_range(1)), bin2bcd(h)[4:0]};
        end
        return bin2bcd(int'($urandom_range(23)));
      end
      3: return 8'($urandom_range(7, 1));
      4: return bin2bcd(int'($urandom_range(28, 1)));
      5: return bin2bcd(int'($urandom_range(12, 1)));
      6: return bin2bcd(int'($urandom_range(99)));
      default: return 8'($urandom_range(255));
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h0005EED1));
    expRegs = {8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkRegs("R1 reset values");

    // R3: control mask
    doCycle(0, 1, 7, 8'hFF, "R3 control keep mask");
    doCycle(0, 1, 7, 8'h6C, "R3 control dropped bits");
    // R2: masked fields and placement
    doCycle(0, 1, 3, 8'hFF, "R2 day-of-week mask");
    doCycle(0, 1, 1, 8'hFF, "R2 minutes mask");
    doCycle(0, 1, 5, 8'hE9, "R2 month mask");
    doCycle(0, 1, 4, 8'hD7, "R2 date mask");

    // R4 R5 R7 R8: full cascade out of 23:59:59 Sunday, Dec 31, 99
    loadTime(8'h23, 8'h07, 8'h31, 8'h12, 8'h99, "R2 load");
    doCycle(1, 0, 0, 0, "R4 R5 R7 R8 year wrap cascade");
    doCycle(1, 0, 0, 0, "R4 seconds count");

    // R8: 30-day month
    loadTime(8'h23, 8'h03, 8'h30, 8'h04, 8'h21, "R2 load");
    doCycle(1, 0, 0, 0, "R8 April end");
    loadTime(8'h23, 8'h03, 8'h30, 8'h05, 8'h21, "R2 load");
    doCycle(1, 0, 0, 0, "R8 May 30 to 31");

    // R9: February
    loadTime(8'h23, 8'h02, 8'h28, 8'h02, 8'h24, "R2 load");
    doCycle(1, 0, 0, 0, "R9 leap Feb 28 to 29");
    doCycle(0, 1, 0, 8'h59, "R2 load");
    doCycle(0, 1, 1, 8'h59, "R2 load");
    doCycle(0, 1, 2, 8'h23, "R2 load");
    doCycle(1, 0, 0, 0, "R9 leap Feb 29 to Mar 1");
    loadTime(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, "R2 load");
    doCycle(1, 0, 0, 0, "R9 common Feb 28 to Mar 1");
    loadTime(8'h23, 8'h02, 8'h28, 8'h02, 8'h10, "R2 load");
    doCycle(1, 0, 0, 0, "R9 odd-tens non-leap year");

    // R6: 12-hour mode
    loadTime(8'h51, 8'h04, 8'h10, 8'h06, 8'h30, "R2 load");
    doCycle(1, 0, 0, 0, "R6 11 AM to 12 PM");
    doCycle(0, 1, 0, 8'h59, "R2 load");
    doCycle(0, 1, 1, 8'h59, "R2 load");
    doCycle(1, 0, 0, 0, "R6 12 PM to 1 PM");
    loadTime(8'h71, 8'h04, 8'h10, 8'h06, 8'h30, "R2 load");
    doCycle(1, 0, 0, 0, "R6 11 PM to 12 AM day carry");

    // R10: halt and resume
    doCycle(0, 1, 0, 8'hB0, "R10 set halt");
    for (int i = 0; i < 5; i++) doCycle(1, 0, 0, 0, "R10 ticks ignored while halted");
    doCycle(0, 1, 0, 8'h30, "R10 clear halt");
    doCycle(1, 0, 0, 0, "R10 resume counting");

    // R11: collisions
    doCycle(1, 1, 0, 8'h10, "R11 seconds write drops tick");
    doCycle(1, 1, 1, 8'h05, "R11 other write with advance");
    doCycle(1, 1, 0, 8'h80, "R11 halt write in tick cycle");
    doCycle(1, 0, 0, 0, "R10 halted after collision");
    doCycle(0, 1, 0, 8'h00, "R10 resume");

    // random phase across R2 R4 R5 R6 R7 R8 R10 R11
    for (int n = 0; n < 4000; n++) begin
      bit t, w;
      int a;
      t = ($urandom_range(1) == 1);
      w = ($urandom_range(3) == 0);
      a = int'($urandom_range(7));
      doCycle(t, w, a, randValid(a), "R4 R8 R11 random mix");
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule